// File: doc/BRIEF.md
# Frequency Sweep Acquisition Controller

This block helps a clock-recovery PLL reach the frequency of incoming data. It drives a digital control word that stands in for the loop-filter voltage of the VCO. Each acquisition cycle begins at the low edge of a band that spans ten percent either side of the centre value. The word then ramps upward in fixed steps. If lock has not been reached at the top of the band, the word ramps back down. At the bottom the controller waits for one slow-clock period before it starts the next cycle. One cycle therefore lasts the sweep time plus one slow-clock period.

All stepping is paced by a slow system clock that has no relation to the data rate. That clock enters asynchronously: it is synchronized, and each rising edge becomes one step opportunity. When the lock flag is high, the word and the sweep position are frozen. When the data-present flag drops, they are also frozen, so that reacquisition starts from the last rate reached instead of from the start of the band.

Top module: `sweep_acq_ctrl`

## Requirements
- R1: While rst_ni is low, ctrl_word_o equals the band floor CENTRE-HALF_SPAN and dir_up_o is 1.
- R2: In the upward phase, each step adds STEP to the word and saturates at the ceiling CENTRE+HALF_SPAN. The step that reaches the ceiling switches the controller to the downward phase (dir_up_o = 0).
- R3: In the downward phase, each step subtracts STEP and saturates at the floor. The step that reaches the floor enters a settle phase that lasts exactly one step opportunity. During that phase dir_up_o = 1 and the word stays at the floor.
- R4: The step opportunity that ends the settle phase changes nothing but the phase. The next opportunity steps upward from the floor, which starts a new cycle of up steps, then down steps, then one settle step.
- R5: A step opportunity that occurs while lock_i = 1 leaves the word and the phase unchanged. sweeping_o is 0 while lock_i = 1.
- R6: A step opportunity that occurs while data_ok_i = 0 leaves the word and the phase unchanged. sweeping_o is 0 while data_ok_i = 0. Once data returns, sweeping resumes from the held word in the held direction.
- R7: Each rising edge of sys_clk_i gives exactly one step opportunity. Its effect appears at the (SYNC_STAGES+1)-th rising edge of clk_i after sys_clk_i rises. A level held high gives no further steps.
- R8: ctrl_word_o never leaves the range from the floor to the ceiling. sweeping_o is 1 exactly when data_ok_i = 1, lock_i = 0, and the controller is not in the settle phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast logic clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_clk_i | input | 1 | Slow system clock, asynchronous to clk_i |
| data_ok_i | input | 1 | High while input data transitions are present |
| lock_i | input | 1 | High while the PLL is lock-qualified |
| ctrl_word_o | output | CW_W | VCO control word |
| dir_up_o | output | 1 | 1 when the sweep direction is up (up phase or settle) |
| sweeping_o | output | 1 | 1 while a sweep step can be taken |

## Verification
A step caused by a rising edge of sys_clk_i shows on ctrl_word_o and dir_up_o at the third clk_i edge after the rise, which is SYNC_STAGES+1 with two stages. The bench therefore applies each slow-clock pulse and samples on falling edges only after that edge, checking once that the second falling edge still shows the old word. sweeping_o is combinational from data_ok_i, lock_i and the phase, so it is checked half a cycle after those inputs change. Expected words come from an arithmetic model of the saturating ramp, stepped once per pulse, over several full cycles and with lock and data loss applied in every phase.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef enum logic [1:0] {
    PH_UP     = 2'd0,
    PH_DOWN   = 2'd1,
    PH_SETTLE = 2'd2
  } sweep_phase_e;
endpackage

// File: rtl/sysclk_tick.sv
module sysclk_tick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_clk_i,
  output logic tick_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= sys_clk_i;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign tick_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R7: one opportunity per slow edge
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sweep_step.sv
module sweep_step #(
  parameter int CW_W      = 10,
  parameter int CENTRE    = 512,
  parameter int HALF_SPAN = 51,
  parameter int STEP      = 4
) (
  input  logic [CW_W-1:0] cw_i,
  input  logic            up_i,
  output logic [CW_W-1:0] nxt_o,
  output logic            at_lim_o
);
  localparam int LO = CENTRE - HALF_SPAN;
  localparam int HI = CENTRE + HALF_SPAN;
  localparam logic [CW_W:0] HI_X   = (CW_W+1)'(HI);
  localparam logic [CW_W:0] STEP_X = (CW_W+1)'(STEP);
  localparam logic [CW_W:0] DN_TH  = (CW_W+1)'(LO + STEP);

  logic [CW_W:0] sum;
  logic [CW_W:0] cw_x;

  assign cw_x = {1'b0, cw_i};
  assign sum  = cw_x + STEP_X;

  always_comb begin
    if (up_i) begin
      at_lim_o = (sum >= HI_X);
      nxt_o    = at_lim_o ? CW_W'(HI) : sum[CW_W-1:0];
    end else begin
      at_lim_o = (cw_x <= DN_TH);
      nxt_o    = at_lim_o ? CW_W'(LO) : cw_i - CW_W'(STEP);
    end
  end
endmodule

// File: rtl/sweep_fsm.sv
module sweep_fsm
  import sweep_pkg::*;
#(
  parameter int CW_W      = 10,
  parameter int CENTRE    = 512,
  parameter int HALF_SPAN = 51
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            data_ok_i,
  input  logic            lock_i,
  input  logic [CW_W-1:0] nxt_i,
  input  logic            at_lim_i,
  output logic [CW_W-1:0] cw_o,
  output sweep_phase_e    phase_o
);
  localparam logic [CW_W-1:0] LO_W = CW_W'(CENTRE - HALF_SPAN);

  logic         run;
  sweep_phase_e phase_q, phase_d;
  logic [CW_W-1:0] cw_q, cw_d;

  assign run = tick_i & data_ok_i & ~lock_i;

  always_comb begin
    phase_d = phase_q;
    cw_d    = cw_q;
    if (run) begin
      unique case (phase_q)
        PH_UP: begin
          cw_d = nxt_i;
          if (at_lim_i) phase_d = PH_DOWN;
        end
        PH_DOWN: begin
          cw_d = nxt_i;
          if (at_lim_i) phase_d = PH_SETTLE;
        end
        default: phase_d = PH_UP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_UP;
      cw_q    <= LO_W;
    end else begin
      phase_q <= phase_d;
      cw_q    <= cw_d;
    end
  end

  assign cw_o    = cw_q;
  assign phase_o = phase_q;

  a_r5_hold_on_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> ($stable(cw_q) && $stable(phase_q)));
  a_r6_hold_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_ok_i |=> ($stable(cw_q) && $stable(phase_q)));
  a_r3_settle_one_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && phase_q == PH_SETTLE) |=> (phase_q == PH_UP && $stable(cw_q)));
  a_r2_turn_at_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && phase_q == PH_UP && at_lim_i) |=> phase_q == PH_DOWN);
  a_r7_no_step_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cw_q));
endmodule

// File: rtl/sweep_acq_ctrl.sv
module sweep_acq_ctrl
  import sweep_pkg::*;
#(
  parameter int CW_W        = 10,
  parameter int CENTRE      = 512,
  parameter int HALF_SPAN   = 51,
  parameter int STEP        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sys_clk_i,
  input  logic            data_ok_i,
  input  logic            lock_i,
  output logic [CW_W-1:0] ctrl_word_o,
  output logic            dir_up_o,
  output logic            sweeping_o
);
  localparam logic [CW_W-1:0] LO_W = CW_W'(CENTRE - HALF_SPAN);
  localparam logic [CW_W-1:0] HI_W = CW_W'(CENTRE + HALF_SPAN);

  logic            tick;
  logic [CW_W-1:0] cw, nxt;
  logic            at_lim;
  sweep_phase_e    phase;

  sysclk_tick #(.SYNC_STAGES(SYNC_STAGES)) i_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sys_clk_i (sys_clk_i),
    .tick_o    (tick)
  );

  sweep_step #(.CW_W(CW_W), .CENTRE(CENTRE), .HALF_SPAN(HALF_SPAN), .STEP(STEP)) i_step (
    .cw_i     (cw),
    .up_i     (phase != PH_DOWN),
    .nxt_o    (nxt),
    .at_lim_o (at_lim)
  );

  sweep_fsm #(.CW_W(CW_W), .CENTRE(CENTRE), .HALF_SPAN(HALF_SPAN)) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .data_ok_i (data_ok_i),
    .lock_i    (lock_i),
    .nxt_i     (nxt),
    .at_lim_i  (at_lim),
    .cw_o      (cw),
    .phase_o   (phase)
  );

  assign ctrl_word_o = cw;
  assign dir_up_o    = (phase != PH_DOWN);
  assign sweeping_o  = data_ok_i & ~lock_i & (phase != PH_SETTLE);

  a_r8_in_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_word_o >= LO_W) && (ctrl_word_o <= HI_W));
  a_r8_valid_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase inside {PH_UP, PH_DOWN, PH_SETTLE});
endmodule

// File: tb/test_sweep_acq_ctrl.sv
`timescale 1ns/1ps
module test_sweep_acq_ctrl;
  localparam int CW_W = 8, CENTRE = 128, HALF_SPAN = 12, STEP = 5, SYNC = 2;
  localparam int LO = CENTRE - HALF_SPAN, HI = CENTRE + HALF_SPAN;

  logic clk = 0, rst_ni = 0, sys_clk = 0, data_ok = 0, lock = 0;
  logic [CW_W-1:0] word;
  logic dir_up, sweeping;
  int checks = 0, fails = 0;
  bit done = 0;

  // model: 0 up, 1 down, 2 settle
  int m_ph = 0, m_w = LO;

  always #2.5 clk = ~clk;

  sweep_acq_ctrl #(.CW_W(CW_W), .CENTRE(CENTRE), .HALF_SPAN(HALF_SPAN),
                   .STEP(STEP), .SYNC_STAGES(SYNC)) i_sweep_acq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .sys_clk_i(sys_clk), .data_ok_i(data_ok),
    .lock_i(lock), .ctrl_word_o(word), .dir_up_o(dir_up), .sweeping_o(sweeping));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " word"}, int'(word), m_w);
    chk({req, " dir"}, int'(dir_up), (m_ph != 1) ? 1 : 0);
    chk({req, " sweeping"}, int'(sweeping), (data_ok && !lock && m_ph != 2) ? 1 : 0);
  endtask

  task automatic model_step();
    if (data_ok && !lock) begin
      case (m_ph)
        0: begin m_w = m_w + STEP; if (m_w >= HI) begin m_w = HI; m_ph = 1; end end
        1: begin if (m_w <= LO + STEP) begin m_w = LO; m_ph = 2; end else m_w = m_w - STEP; end
        default: m_ph = 0;
      endcase
    end
  endtask

  task automatic pulse(input string req);
    @(negedge clk); sys_clk = 1;
    repeat (4) @(negedge clk);
    sys_clk = 0;
    repeat (4) @(negedge clk);
    model_step();
    chk_all(req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1 reset");
    chk("R1 reset word", int'(word), LO);
    rst_ni = 1;
    data_ok = 1;
    @(negedge clk);
    chk_all("R8 sweeping after reset");

    // R7 latency: old word at 2nd negedge, new at 3rd; held high gives one step
    @(negedge clk); sys_clk = 1;
    repeat (2) @(negedge clk);
    chk("R7 not yet", int'(word), m_w);
    @(negedge clk);
    model_step();
    chk("R7 due", int'(word), m_w);
    repeat (20) @(negedge clk);
    chk("R7 level held", int'(word), m_w);
    sys_clk = 0;
    repeat (4) @(negedge clk);

    // R2 R3 R4: three full cycles
    for (int i = 0; i < 33; i++) pulse("R2/R3/R4 sweep");

    // R5: lock in each phase position
    for (int k = 0; k < 11; k++) begin
      @(negedge clk); lock = 1;
      @(negedge clk); chk_all("R5 lock sweeping");
      pulse("R5 lock hold");
      pulse("R5 lock hold2");
      lock = 0;
      pulse("R5 resume");
    end

    // R6: data loss in each phase position
    for (int k = 0; k < 11; k++) begin
      @(negedge clk); data_ok = 0;
      @(negedge clk); chk_all("R6 no data sweeping");
      pulse("R6 hold");
      pulse("R6 hold2");
      data_ok = 1;
      pulse("R6 resume");
    end

    // R8: long free run
    for (int i = 0; i < 25; i++) begin
      pulse("R8 free run");
      chk("R8 band", (int'(word) >= LO && int'(word) <= HI) ? 1 : 0, 1);
    end

    // R1: reset mid-sweep
    @(negedge clk); rst_ni = 0;
    @(negedge clk);
    m_w = LO; m_ph = 0;
    chk_all("R1 reset mid-sweep");
    rst_ni = 1;
    pulse("R2 after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule